// File: doc/BRIEF.md
# Double-Buffered Synchronous Master Serial Transmitter

This block sends 8-bit or 9-bit words over a two-wire synchronous link on which it is the clock master. It drives a serial clock and a serial data line. A host places a word, and its optional ninth bit, into a one-entry holding buffer. The word moves into a private shift register only when the shift register has nothing left to send. The host can therefore queue the next word while the current one is still shifting out.

Two status indications come back. The buffer-empty flag goes high when the holding buffer hands its word to the shift register. The host cannot clear it; only the next write clears it. The flag can be routed to an interrupt output. A separate shift-register-empty bit tells the host when the line has gone quiet. No interrupt is attached to that bit, so the host polls it. Because the link is half-duplex, the block also outputs a data-drive signal, and any receiver sharing the data wire must hold off while that signal is high.

The bit clock period is 4×(divisor+1) system clocks. Data changes when the serial clock falls and is stable when it rises.

Top module: `sync_master_tx`

## Requirements
- R1: After reset, sr_empty is 1, and buf_empty, irq, ser_clk, ser_dat and dat_drive are all 0.
- R2: Frames are sent only while port_en, sync_mode, clk_master and tx_en are all 1. If any of them is 0, a written word waits in the holding buffer, no serial clock pulses appear, and buf_empty stays 0. The word is sent once all four are 1.
- R3: Data bits leave least significant bit first. Each bit is placed on ser_dat while ser_clk is low and holds steady while ser_clk is high, so a receiver samples it on the rising edge.
- R4: Rising edges of ser_clk are spaced 4×(div+1) system clocks apart throughout a frame, with the clock high for the second half of each bit.
- R5: When nine_bit is 1 at the moment a word is transferred, the frame carries 9 bits. The ninth bit is the wr_bit9 value captured with that word. Otherwise the frame carries 8 bits.
- R6: When the shift register is idle and the block is enabled, a word written on one clock edge is transferred on the next clock edge. On that second edge buf_empty becomes 1 and sr_empty becomes 0.
- R7: A write clears buf_empty on the clock edge that accepts it. Nothing else clears it, and irq_en has no effect on it. irq equals buf_empty AND irq_en.
- R8: A word written while a frame is shifting is transferred as soon as the last bit's high phase ends. The next frame follows with no extra idle time, so the rising-edge spacing stays 4×(div+1) across the boundary.
- R9: When the last bit ends and the holding buffer is empty, sr_empty returns to 1, and ser_clk and ser_dat go low and stay low.
- R10: Clearing tx_en or port_en during a frame aborts it. On the next clock edge, sr_empty is 1 and ser_clk, ser_dat and dat_drive are 0.
- R11: dat_drive, which tells a receiver on the shared wire to hold off, is 1 exactly while sr_empty is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Block sources the serial clock |
| tx_en | input | 1 | Transmit enable |
| nine_bit | input | 1 | Select 9-bit frames |
| irq_en | input | 1 | Route buffer-empty flag to irq |
| div | input | DIV_W | Bit clock divisor |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_byte | input | DATA_W | Word to send |
| wr_bit9 | input | 1 | Ninth bit stored with the word |
| ser_clk | output | 1 | Serial clock line, idles low |
| ser_dat | output | 1 | Serial data line |
| dat_drive | output | 1 | Data line is driven; receive must hold off |
| buf_empty | output | 1 | Holding buffer has been handed to the shift register |
| irq | output | 1 | Buffer-empty interrupt request |
| sr_empty | output | 1 | Shift register holds no pending data |

## Verification
The assertions check, on every cycle, that the serial clock never pulses while the shifter is idle and that data never moves while the clock is high. They also check that buf_empty rises only when a transfer takes place and falls only after a write, and that a lost enable leaves the line idle on the next edge. Only the bench scenarios can show the bit order, the 8-bit and 9-bit contents, the exact rising-edge spacing for several divisors, and the absence of a gap between back-to-back frames. The same applies to the word held while the port is gated and to the independence of the flag from irq_en. Those scenarios mix seeded random words, divisors and frame lengths with directed cases.

// File: rtl/sm_tx_pkg.sv
package sm_tx_pkg;

  // index of the final bit in a frame of the given length
  function automatic int unsigned frame_last(input int unsigned data_w, input logic ninth);
    return ninth ? data_w : data_w - 1;
  endfunction

endpackage

// File: rtl/sm_tx_bitclk.sv
module sm_tx_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             bit_end,
  output logic             sck_hi
);

  localparam int CW = DIV_W + 3;

  logic [CW-1:0] cnt;
  logic [DIV_W:0] dp1;
  logic [CW-1:0] half_cnt;
  logic [CW-1:0] limit;

  assign dp1      = {1'b0, div} + 1'b1;
  assign half_cnt = {1'b0, dp1, 1'b0};
  assign limit    = {dp1, 2'b00} - 1'b1;

  assign bit_end = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt    <= '0;
      sck_hi <= 1'b0;
    end else if (cnt == limit) begin
      cnt    <= '0;
      sck_hi <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == half_cnt - 1'b1) sck_hi <= 1'b1;
    end
  end

  // R4
  sck_low_after_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> !sck_hi);

endmodule

// File: rtl/sm_tx_holdbuf.sv
module sm_tx_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              wr_b9,
  input  logic              take,
  output logic [DATA_W-1:0] hold_byte,
  output logic              hold_b9,
  output logic              full,
  output logic              empty_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_byte  <= '0;
      hold_b9    <= 1'b0;
      full       <= 1'b0;
      empty_flag <= 1'b0;
    end else if (wr) begin
      hold_byte  <= wr_byte;
      hold_b9    <= wr_b9;
      full       <= 1'b1;
      empty_flag <= 1'b0;
    end else if (take) begin
      full       <= 1'b0;
      empty_flag <= 1'b1;
    end
  end

  // R7
  flag_drop_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(empty_flag) |-> $past(wr));

  // R6
  flag_rise_needs_take_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_flag) |-> $past(take));

endmodule

// File: rtl/sm_tx_shifter.sv
module sm_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              bit_end,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_byte,
  input  logic              buf_b9,
  input  logic              nine,
  output logic              load,
  output logic              busy,
  output logic              sdat
);

  import sm_tx_pkg::*;

  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(frame_last(DATA_W, 1'b0));
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(frame_last(DATA_W, 1'b1));

  logic [DATA_W:0]  sh;
  logic [IDX_W-1:0] idx;
  logic             nine_q;
  logic             frame_done;

  assign frame_done = busy && bit_end && (idx == (nine_q ? LAST_LONG : LAST_SHORT));
  assign load       = active && buf_full && (!busy || frame_done);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sh     <= '0;
      idx    <= '0;
      nine_q <= 1'b0;
      busy   <= 1'b0;
      sdat   <= 1'b0;
    end else if (load) begin
      sh     <= {buf_b9, buf_byte};
      idx    <= '0;
      nine_q <= nine;
      busy   <= 1'b1;
      sdat   <= buf_byte[0];
    end else if (frame_done) begin
      busy <= 1'b0;
      sdat <= 1'b0;
    end else if (busy && bit_end) begin
      sh   <= sh >> 1;
      sdat <= sh[1];
      idx  <= idx + 1'b1;
    end
  end

  // R9
  idle_line_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sdat);

endmodule

// File: rtl/sync_master_tx.sv
module sync_master_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_master,
  input  logic              tx_en,
  input  logic              nine_bit,
  input  logic              irq_en,
  input  logic [DIV_W-1:0]  div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              wr_bit9,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              dat_drive,
  output logic              buf_empty,
  output logic              irq,
  output logic              sr_empty
);

  logic              active;
  logic              take;
  logic              busy;
  logic              bit_end;
  logic              sck_hi;
  logic              full;
  logic [DATA_W-1:0] hold_byte;
  logic              hold_b9;

  assign active = port_en && sync_mode && clk_master && tx_en;

  sm_tx_holdbuf #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr(wr_en), .wr_byte(wr_byte), .wr_b9(wr_bit9),
    .take(take), .hold_byte(hold_byte), .hold_b9(hold_b9), .full(full),
    .empty_flag(buf_empty)
  );

  sm_tx_bitclk #(.DIV_W(DIV_W)) u_bclk (
    .clk(clk), .rst(rst), .run(busy && active), .restart(take), .div(div),
    .bit_end(bit_end), .sck_hi(sck_hi)
  );

  sm_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .active(active), .bit_end(bit_end), .buf_full(full),
    .buf_byte(hold_byte), .buf_b9(hold_b9), .nine(nine_bit), .load(take),
    .busy(busy), .sdat(ser_dat)
  );

  assign ser_clk   = sck_hi && busy;
  assign sr_empty  = !busy;
  assign dat_drive = busy;
  assign irq       = buf_empty && irq_en;

  // R9
  no_clock_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    sr_empty |-> !ser_clk);

  // R3
  data_steady_while_high_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && !$rose(busy)) |-> $stable(ser_dat));

  // R10
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (sr_empty && !ser_clk && !ser_dat));

  // R2
  gated_no_transfer_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !wr_en) |=> !$rose(buf_empty));

endmodule

// File: tb/sync_master_tx_tb.sv
module sync_master_tx_tb;

  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en = 0, sync_mode = 0, clk_master = 0, tx_en = 0, nine_bit = 0, irq_en = 0;
  logic [DIV_W-1:0]  div = '0;
  logic              wr_en = 0;
  logic [DATA_W-1:0] wr_byte = '0;
  logic              wr_bit9 = 0;
  logic ser_clk, ser_dat, dat_drive, buf_empty, irq, sr_empty;

  always #2.5 clk = ~clk;

  sync_master_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .port_en(port_en), .sync_mode(sync_mode),
    .clk_master(clk_master), .tx_en(tx_en), .nine_bit(nine_bit), .irq_en(irq_en),
    .div(div), .wr_en(wr_en), .wr_byte(wr_byte), .wr_bit9(wr_bit9),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .dat_drive(dat_drive),
    .buf_empty(buf_empty), .irq(irq), .sr_empty(sr_empty)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rises = 0;
  int last_rise = 0;
  int period_exp = 4;
  bit spacing_bad = 0;
  logic [63:0] cap = '0;
  logic prev_sck = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // rising-edge capture of the serial line
  always @(negedge clk) begin
    if (ser_clk && !prev_sck) begin
      if (rises < 64) cap[rises] = ser_dat;
      if (rises > 0 && (cyc - last_rise) != period_exp) spacing_bad = 1;
      last_rise = cyc;
      rises++;
    end
    prev_sck = ser_clk;
  end

  function automatic logic [63:0] exp_frame(input logic [7:0] b, input logic b9);
    return {55'd0, b9, b};
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic clear_cap();
    @(negedge clk); #1;
    rises = 0; spacing_bad = 0; cap = '0;
  endtask

  task automatic send(input logic [7:0] b, input logic b9);
    @(negedge clk); #1;
    wr_en = 1; wr_byte = b; wr_bit9 = b9;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic wait_idle();
    while (!sr_empty) begin
      @(negedge clk); #1;
    end
    tick(2);
  endtask

  task automatic set_all(input logic v);
    @(negedge clk); #1;
    port_en = v; sync_mode = v; clk_master = v; tx_en = v;
  endtask

  task automatic check_frame(input string req, input logic [63:0] exp, input int nbits);
    logic [63:0] mask;
    mask = (64'd1 << nbits) - 1;
    chk(rises == nbits, req, rises, nbits);
    chk((cap & mask) == (exp & mask), req, int'(cap[31:0]), int'(exp[31:0]));
    chk(!spacing_bad, "R4", int'(spacing_bad), 0);
  endtask

  initial begin
    logic [7:0] b, b2;
    logic b9, nb;
    void'($urandom(32'd2024));
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state
    chk(sr_empty == 1, "R1", sr_empty, 1);
    chk(buf_empty == 0, "R1", buf_empty, 0);
    chk({ser_clk, ser_dat, dat_drive, irq} == 4'b0, "R1", {ser_clk, ser_dat, dat_drive, irq}, 0);

    // R2: gated port holds the word
    div = 8'd1; period_exp = 8;
    @(negedge clk); #1;
    port_en = 1; clk_master = 1; tx_en = 1; sync_mode = 0;
    clear_cap();
    send(8'hA5, 1'b0);
    tick(60);
    chk(rises == 0, "R2", rises, 0);
    chk(sr_empty == 1, "R2", sr_empty, 1);
    chk(buf_empty == 0, "R2", buf_empty, 0);
    @(negedge clk); #1; sync_mode = 1;
    tick(3);
    wait_idle();
    check_frame("R2", exp_frame(8'hA5, 1'b0), 8);

    // R6 / R7 / R3 directed single frame
    div = 8'd0; period_exp = 4;
    clear_cap();
    send(8'h3C, 1'b0);
    chk(buf_empty == 0, "R7", buf_empty, 0);
    tick(1);
    chk(buf_empty == 1, "R6", buf_empty, 1);
    chk(sr_empty == 0, "R6", sr_empty, 0);
    chk(dat_drive == 1, "R11", dat_drive, 1);
    wait_idle();
    check_frame("R3", exp_frame(8'h3C, 1'b0), 8);
    chk(ser_clk == 0 && ser_dat == 0, "R9", {ser_clk, ser_dat}, 0);
    chk(dat_drive == 0, "R11", dat_drive, 0);

    // R7 flag independent of irq_en, only cleared by a write
    @(negedge clk); #1; irq_en = 0;
    tick(1);
    chk(irq == 0, "R7", irq, 0);
    chk(buf_empty == 1, "R7", buf_empty, 1);
    @(negedge clk); #1; irq_en = 1;
    tick(40);
    chk(irq == 1, "R7", irq, 1);
    chk(buf_empty == 1, "R7", buf_empty, 1);

    // R5 nine-bit directed
    @(negedge clk); #1; nine_bit = 1; div = 8'd2; period_exp = 12;
    clear_cap();
    send(8'h00, 1'b1);
    tick(2);
    wait_idle();
    check_frame("R5", exp_frame(8'h00, 1'b1), 9);

    // R8 back-to-back frames
    @(negedge clk); #1; nine_bit = 0; div = 8'd1; period_exp = 8;
    clear_cap();
    send(8'h81, 1'b0);
    tick(1);
    send(8'h7E, 1'b0);
    chk(buf_empty == 0, "R8", buf_empty, 0);
    tick(2);
    wait_idle();
    chk(rises == 16, "R8", rises, 16);
    chk(cap[15:0] == 16'h7E81, "R8", int'(cap[15:0]), 32385);
    chk(!spacing_bad, "R8", int'(spacing_bad), 0);

    // R10 abort via tx_en and via port_en
    @(negedge clk); #1; div = 8'd3; period_exp = 16;
    send(8'hFF, 1'b0);
    tick(20);
    chk(sr_empty == 0, "R10", sr_empty, 0);
    @(negedge clk); #1; tx_en = 0;
    tick(1);
    chk(sr_empty == 1 && ser_clk == 0 && ser_dat == 0 && dat_drive == 0, "R10",
        {sr_empty, ser_clk, ser_dat, dat_drive}, 8);
    @(negedge clk); #1; tx_en = 1;
    send(8'hFF, 1'b0);
    tick(30);
    @(negedge clk); #1; port_en = 0;
    tick(1);
    chk(sr_empty == 1 && ser_clk == 0 && ser_dat == 0, "R10",
        {sr_empty, ser_clk, ser_dat}, 4);
    set_all(1'b1);
    tick(2);

    // random frames
    for (int k = 0; k < 24; k++) begin
      b  = 8'($urandom);
      b9 = 1'($urandom);
      nb = 1'($urandom);
      @(negedge clk); #1;
      div = 8'($urandom_range(0, 7));
      nine_bit = nb;
      period_exp = 4 * (int'(div) + 1);
      clear_cap();
      if (k % 3 == 2) begin
        b2 = 8'($urandom);
        send(b, b9);
        tick(1);
        send(b2, ~b9);
        tick(2);
        wait_idle();
        chk(rises == (nb ? 18 : 16), "R8", rises, nb ? 18 : 16);
        if (nb) chk(cap[17:0] == {~b9, b2, b9, b}, "R5", int'(cap[17:0]), int'({~b9, b2, b9, b}));
        else    chk(cap[15:0] == {b2, b}, "R3", int'(cap[15:0]), int'({b2, b}));
        chk(!spacing_bad, "R4", int'(spacing_bad), 0);
      end else begin
        send(b, b9);
        tick(1);
        chk(buf_empty == 1 && sr_empty == 0, "R6", {buf_empty, sr_empty}, 2);
        wait_idle();
        check_frame(nb ? "R5" : "R3", exp_frame(b, b9), nb ? 9 : 8);
      end
      chk(sr_empty == 1 && ser_clk == 0, "R9", {sr_empty, ser_clk}, 2);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule